// File: doc/BRIEF.md
# Staged Power-On Reset Sequencer

This block produces two system resets from one asynchronous external reset request. One reset goes to the clock-generation PLLs and the other to the processor, memory controller and peripheral logic. Both resets assert together, at once, whenever a reset source is active. They release in a fixed order. The PLL reset releases after a short hold. The system reset releases after a much longer hold, so that an external memory does not begin calibrating too soon after power-up or reconfiguration. All timing is counted in cycles of a free-running reference clock that no PLL produces. The hold lengths are parameters, so a simulation can use small values.

The PLL lock inputs act as reset sources. Each one passes through a synchroniser and a filter, and it counts as stable only after it has stayed high for a programmable run of consecutive cycles. A resync window opens when the PLL reset releases. During that window a lock input may toggle and nothing happens. Once the window closes, a lock input that is not stable restarts the whole sequence. While the system reset is released, a failure flag from the memory controller also restarts the sequence. A saturating retry counter flags repeated restarts. A sticky output records a failed memory start, and a ready output reports a completed one.

Parameter rules: `SYS_HOLD_CYC` must be greater than `PLL_HOLD_CYC + RESYNC_CYC`, and `LOCK_STABLE_CYC + 2` must be smaller than `RESYNC_CYC`.

Top module: `por_sequencer`

## Requirements
- R1: While `ext_rst` is 1, `pll_rst` and `sys_rst` are 1 without waiting for a clock edge. In the same condition `ready`, `mem_fail` and `retry_err` are 0.
- R2: `pll_rst` goes to 0 on rising edge number `PLL_HOLD_CYC`+3 of `clk_ref` after `ext_rst` falls: two synchroniser edges, then `PLL_HOLD_CYC`+1 counting edges. `sys_rst` is never 0 while `pll_rst` is 1.
- R3: `sys_rst` goes to 0 no earlier than rising edge `SYS_HOLD_CYC`+3 after `ext_rst` falls. It goes to 0 on exactly that edge if every lock input is stable at that point.
- R4: A lock input passes a two-flop synchroniser. It counts as stable once its synchronised value has been 1 for `LOCK_STABLE_CYC` consecutive edges, and it becomes unstable as soon as a 0 sample arrives. The resync window lasts `RESYNC_CYC` cycles from the release of `pll_rst`, and lock drops inside it cause no restart.
- R5: After the resync window, a 0 sample on any lock input asserts both resets together within four edges. The sequence then starts again from the beginning.
- R6: If any lock input is not stable when the resync window closes, both resets assert again exactly `RESYNC_CYC` edges after `pll_rst` fell. `sys_rst` stays 1 throughout.
- R7: Each restart raises a retry count, which saturates at `RETRY_MAX`. `retry_err` is 1 while the count equals `RETRY_MAX`, and only `ext_rst` clears it.
- R8: `ready` is 1 only while `sys_rst` is 0, the synchronised init-done flag is 1 and neither synchronised fail flag is 1. It follows these conditions one edge after the synchroniser.
- R9: While `sys_rst` is 0, a synchronised calibration-fail or init-fail flag restarts the sequence. It also sets `mem_fail`, which stays 1 until `ext_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, not derived from any PLL |
| ext_rst | input | 1 | External reset request, asynchronous, active high |
| pll_locked | input | NUM_PLL | Lock indications from the PLLs |
| mem_init_done | input | 1 | Memory controller reports initialisation complete |
| mem_cal_fail | input | 1 | Memory controller reports calibration failure |
| mem_init_fail | input | 1 | Memory controller reports initialisation failure |
| pll_rst | output | 1 | Reset to the PLLs, active high |
| sys_rst | output | 1 | Reset to processor, memory and peripheral logic, active high |
| ready | output | 1 | System out of reset with memory initialised |
| mem_fail | output | 1 | Sticky flag: a memory start has failed |
| retry_err | output | 1 | Retry count has reached its limit |

## Verification
The assertions check the properties that hold on every cycle: the system reset is never released while the PLL reset is asserted, a re-asserted PLL reset always comes with the system reset, `ready` is never high during system reset, the error and failure flags are sticky, and an active external reset holds both resets. The exact release edges, the tolerance of lock glitches inside the resync window, the restart caused by a late or lost lock, the restart caused by a memory failure, and retry saturation depend on the history of many cycles. The bench shows these through its scenarios and through a reference model that it compares on every clock.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Memory-controller status flags as one synchronised bundle
  typedef struct packed {
    logic done;
    logic cal_fail;
    logic init_fail;
  } mem_flags_t;

  localparam int unsigned MEM_FLAG_W = $bits(mem_flags_t);

endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchroniser with asynchronous preset/clear to RST_VAL
module rstseq_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/rstseq_lock_filter.sv
// Synchronises one lock input and declares it stable after a run of highs
module rstseq_lock_filter #(
  parameter int unsigned STABLE_CYC = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic srst,
  input  logic lock_raw,
  output logic stable
);

  localparam int unsigned CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic          lock_s;
  logic [CW-1:0] run_cnt;

  rstseq_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_sync (
    .clk  (clk),
    .rst  (arst),
    .din  (lock_raw),
    .dout (lock_s)
  );

  always_ff @(posedge clk) begin
    if (srst || !lock_s) begin
      run_cnt <= '0;
      stable  <= 1'b0;
    end else if (run_cnt == LAST) begin
      stable  <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int unsigned NUM_PLL         = 2,
  parameter int unsigned PLL_HOLD_CYC    = 50_000,
  parameter int unsigned RESYNC_CYC      = 50_000,
  parameter int unsigned SYS_HOLD_CYC    = 5_000_000,
  parameter int unsigned LOCK_STABLE_CYC = 1024,
  parameter int unsigned RETRY_MAX       = 7
) (
  input  logic               clk_ref,
  input  logic               ext_rst,
  input  logic [NUM_PLL-1:0] pll_locked,
  input  logic               mem_init_done,
  input  logic               mem_cal_fail,
  input  logic               mem_init_fail,
  output logic               pll_rst,
  output logic               sys_rst,
  output logic               ready,
  output logic               mem_fail,
  output logic               retry_err
);
  import rstseq_pkg::*;

  localparam int unsigned TW = $clog2(SYS_HOLD_CYC + 1);
  localparam int unsigned RW = $clog2(RETRY_MAX + 1);
  localparam logic [TW-1:0] T_PLL = TW'(PLL_HOLD_CYC);
  localparam logic [TW-1:0] T_WIN = TW'(PLL_HOLD_CYC + RESYNC_CYC);
  localparam logic [TW-1:0] T_SAT = TW'(SYS_HOLD_CYC);
  localparam logic [RW-1:0] R_MAX = RW'(RETRY_MAX);

  logic               rst_s;
  logic [NUM_PLL-1:0] lock_ok;
  logic               all_ok;
  mem_flags_t         mem_raw, mem_s;
  logic               mem_bad, post_win, restart;

  logic [TW-1:0] elapsed;
  logic [RW-1:0] retries;
  logic          pll_q, sys_q, ready_q, memfail_q;

  // External reset: asserts at once, releases after two reference edges
  rstseq_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_rst_sync (
    .clk  (clk_ref),
    .rst  (ext_rst),
    .din  (1'b0),
    .dout (rst_s)
  );

  assign mem_raw = '{done: mem_init_done, cal_fail: mem_cal_fail, init_fail: mem_init_fail};

  rstseq_sync #(.W(MEM_FLAG_W), .STAGES(2), .RST_VAL(1'b0)) u_mem_sync (
    .clk  (clk_ref),
    .rst  (ext_rst),
    .din  (mem_raw),
    .dout (mem_s)
  );

  // One lock filter per PLL
  generate
    for (genvar g = 0; g < int'(NUM_PLL); g++) begin : g_lock
      rstseq_lock_filter #(.STABLE_CYC(LOCK_STABLE_CYC)) u_filt (
        .clk      (clk_ref),
        .arst     (ext_rst),
        .srst     (rst_s),
        .lock_raw (pll_locked[g]),
        .stable   (lock_ok[g])
      );
    end
  endgenerate

  assign all_ok   = &lock_ok;
  assign mem_bad  = mem_s.cal_fail | mem_s.init_fail;
  assign post_win = (elapsed >= T_WIN);
  assign restart  = (post_win & ~all_ok) | (~sys_q & mem_bad);

  // Elapsed-time counter since sequence start drives both release points
  always_ff @(posedge clk_ref or posedge ext_rst) begin
    if (ext_rst) begin
      elapsed   <= '0;
      pll_q     <= 1'b1;
      sys_q     <= 1'b1;
      ready_q   <= 1'b0;
      retries   <= '0;
      memfail_q <= 1'b0;
    end else if (rst_s) begin
      elapsed <= '0;
      pll_q   <= 1'b1;
      sys_q   <= 1'b1;
      ready_q <= 1'b0;
    end else if (restart) begin
      elapsed <= '0;
      pll_q   <= 1'b1;
      sys_q   <= 1'b1;
      ready_q <= 1'b0;
      if (retries != R_MAX) retries <= retries + 1'b1;
      if (~sys_q & mem_bad) memfail_q <= 1'b1;
    end else begin
      if (elapsed != T_SAT) elapsed <= elapsed + 1'b1;
      pll_q <= (elapsed < T_PLL);
      if ((elapsed >= T_SAT) && all_ok) sys_q <= 1'b0;
      ready_q <= ~sys_q & mem_s.done & ~mem_bad;
    end
  end

  assign pll_rst   = pll_q;
  assign sys_rst   = sys_q;
  assign ready     = ready_q;
  assign mem_fail  = memfail_q;
  assign retry_err = (retries == R_MAX);

endmodule

// File: rtl/por_sequencer_chk.sv
module por_sequencer_chk (
  input logic clk_ref,
  input logic ext_rst,
  input logic pll_rst,
  input logic sys_rst,
  input logic ready,
  input logic mem_fail,
  input logic retry_err
);

  always @(posedge clk_ref) begin
    if (ext_rst) begin
      AST_EXT_HOLDS_BOTH: assert (pll_rst && sys_rst); // R1
    end
  end

  AST_SYS_AFTER_PLL: assert property (@(posedge clk_ref) disable iff (ext_rst)
    pll_rst |-> sys_rst); // R2

  AST_REASSERT_TOGETHER: assert property (@(posedge clk_ref) disable iff (ext_rst)
    $rose(pll_rst) |-> sys_rst); // R5

  AST_RETRY_ERR_STICKY: assert property (@(posedge clk_ref) disable iff (ext_rst)
    retry_err |=> retry_err); // R7

  AST_READY_OUT_OF_RST: assert property (@(posedge clk_ref) disable iff (ext_rst)
    ready |-> !sys_rst); // R8

  AST_MEM_FAIL_STICKY: assert property (@(posedge clk_ref) disable iff (ext_rst)
    mem_fail |=> mem_fail); // R9

endmodule

bind por_sequencer por_sequencer_chk u_chk (
  .clk_ref   (clk_ref),
  .ext_rst   (ext_rst),
  .pll_rst   (pll_rst),
  .sys_rst   (sys_rst),
  .ready     (ready),
  .mem_fail  (mem_fail),
  .retry_err (retry_err)
);

// File: tb/sim_por_sequencer.sv
`timescale 1ns/1ps
module sim_por_sequencer;

  localparam int NP   = 2;
  localparam int PH   = 20;
  localparam int RWIN = 24;
  localparam int SH   = 80;
  localparam int LS   = 4;
  localparam int RM   = 3;
  localparam int LDLY = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          ext_rst = 1'b0;
  logic [NP-1:0] pll_locked = '0;
  logic          mem_init_done = 1'b0, mem_cal_fail = 1'b0, mem_init_fail = 1'b0;
  logic          pll_rst, sys_rst, ready, mem_fail, retry_err;

  por_sequencer #(
    .NUM_PLL(NP), .PLL_HOLD_CYC(PH), .RESYNC_CYC(RWIN), .SYS_HOLD_CYC(SH),
    .LOCK_STABLE_CYC(LS), .RETRY_MAX(RM)
  ) u0 (
    .clk_ref(clk), .ext_rst(ext_rst), .pll_locked(pll_locked),
    .mem_init_done(mem_init_done), .mem_cal_fail(mem_cal_fail), .mem_init_fail(mem_init_fail),
    .pll_rst(pll_rst), .sys_rst(sys_rst), .ready(ready), .mem_fail(mem_fail), .retry_err(retry_err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Behavioural reference state
  bit ms0, ms1;
  bit [NP-1:0] mlk0, mlk1, mst;
  int mcnt [NP];
  bit [2:0] mm0, mm1;           // {done, cal_fail, init_fail}
  int mt, mret;
  bit mpll, msys, mrdy, mmf;

  // PLL stand-in controls
  int rel = 0;
  bit glitch = 0;
  bit [NP-1:0] hold_low = '0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_arst();
    ms0 = 1; ms1 = 1; mlk0 = '0; mlk1 = '0; mm0 = '0; mm1 = '0;
    mt = 0; mpll = 1; msys = 1; mrdy = 0; mret = 0; mmf = 0;
  endtask

  task automatic model_edge();
    bit rs = ms1;
    bit [NP-1:0] lks = mlk1;
    bit [2:0] md = mm1;
    bit allst = &mst;
    bit bad = md[1] | md[0];
    int told = mt;
    bit sold = msys;
    for (int i = 0; i < NP; i++) begin
      if (rs || !lks[i]) begin mcnt[i] = 0; mst[i] = 0; end
      else if (mcnt[i] == LS - 1) mst[i] = 1;
      else mcnt[i]++;
    end
    if (ext_rst) return;
    ms1 = ms0; ms0 = 0;
    mlk1 = mlk0; mlk0 = pll_locked;
    mm1 = mm0; mm0 = {mem_init_done, mem_cal_fail, mem_init_fail};
    if (rs) begin
      mt = 0; mpll = 1; msys = 1; mrdy = 0;
    end else if ((told >= PH + RWIN && !allst) || (!sold && bad)) begin
      if (!sold && bad) mmf = 1;
      mt = 0; mpll = 1; msys = 1; mrdy = 0;
      if (mret < RM) mret++;
    end else begin
      if (mt < SH) mt++;
      mpll = (told < PH);
      if (told >= SH && allst) msys = 0;
      mrdy = !sold && md[2] && !bad;
    end
  endtask

  task automatic drive_locks();
    if (pll_rst) rel = 0; else rel++;
    for (int i = 0; i < NP; i++)
      pll_locked[i] = !pll_rst && rel >= LDLY && !hold_low[i] &&
                      !(glitch && i == 0 && rel >= LDLY + 2 && rel < LDLY + 4);
  endtask

  task automatic compare_all();
    check("R2 pll_rst", int'(pll_rst), int'(mpll));
    check("R3 sys_rst", int'(sys_rst), int'(msys));
    check("R8 ready", int'(ready), int'(mrdy));
    check("R7 retry_err", int'(retry_err), int'(mret == RM));
    check("R9 mem_fail", int'(mem_fail), int'(mmf));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    drive_locks();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    ext_rst = 1'b1;
    model_arst();
    for (int i = 0; i < NP; i++) begin mcnt[i] = 0; mst[i] = 0; end
    repeat (5) tick();
    // R1: reset state
    check("R1 pll_rst in reset", int'(pll_rst), 1);
    check("R1 sys_rst in reset", int'(sys_rst), 1);
    check("R1 ready in reset", int'(ready), 0);

    // Normal start with lock glitches inside the resync window (R2, R3, R4)
    glitch = 1;
    ext_rst = 1'b0;
    n = 0;
    while (pll_rst && n < 500) begin tick(); n++; end
    check("R2 pll release edge", n, PH + 3);
    check("R2 sys held at pll release", int'(sys_rst), 1);
    while (sys_rst && n < 500) begin tick(); n++; end
    check("R3 R4 sys release edge despite window glitches", n, SH + 3);
    glitch = 0;
    check("R8 not ready before init done", int'(ready), 0);
    mem_init_done = 1'b1;
    repeat (4) tick();
    check("R8 ready after init done", int'(ready), 1);

    // R5: lock loss after the window
    hold_low = 2'b10;
    drive_locks();
    tick();
    hold_low = 2'b00;
    repeat (3) tick();
    check("R5 pll_rst after lock loss", int'(pll_rst), 1);
    check("R5 sys_rst after lock loss", int'(sys_rst), 1);
    n = 0;
    while (sys_rst && n < 500) begin tick(); n++; end
    check("R5 sequence restarted and released", int'(sys_rst), 0);
    repeat (4) tick();

    // R9: calibration failure after release
    mem_cal_fail = 1'b1;
    repeat (4) tick();
    check("R9 sys_rst after cal fail", int'(sys_rst), 1);
    check("R9 mem_fail set", int'(mem_fail), 1);
    mem_cal_fail = 1'b0;
    check("R7 no error after two restarts", int'(retry_err), 0);

    // R6: one lock never settles during the window
    hold_low = 2'b10;
    n = 0;
    while (pll_rst && n < 500) begin tick(); n++; end
    n = 0;
    while (!pll_rst && n < 500) begin
      tick(); n++;
      if (!sys_rst) check("R6 sys stays asserted", int'(sys_rst), 1);
    end
    check("R6 restart at window close", n, RWIN);
    tick();
    check("R7 retry_err at limit", int'(retry_err), 1);
    check("R9 mem_fail still set", int'(mem_fail), 1);
    hold_low = 2'b00;

    // R1: asynchronous assertion mid-sequence clears flags
    @(negedge clk);
    ext_rst = 1'b1;
    model_arst();
    #1;
    check("R1 pll_rst immediate", int'(pll_rst), 1);
    check("R1 sys_rst immediate", int'(sys_rst), 1);
    check("R7 retry_err cleared", int'(retry_err), 0);
    check("R9 mem_fail cleared", int'(mem_fail), 0);
    drive_locks();
    repeat (3) tick();
    ext_rst = 1'b0;
    n = 0;
    while (sys_rst && n < 500) begin tick(); n++; end
    check("R3 release after second power-up", n, SH + 3);
    repeat (4) tick();
    check("R8 ready after second power-up", int'(ready), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule